// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler and Descrambler

This block holds a matched pair of bit-serial randomizers that share one polynomial: a 15-stage shift register whose taps sit at stages 7 and 15. The transmit half whitens an outgoing serial stream. Each outgoing bit is the input bit XORed with a tap term. That same outgoing bit is then fed back into stage 1 of its own register, so the transmit half is a multiplicative scrambler. The receive half undoes this. It shifts every received line bit into its own register and XORs the received bit with the tap term taken from that register. Because this is a feed-forward structure, the receive half locks onto the transmitter by itself once 15 line bits have passed through it.

The tap term is the XNOR of stages 7 and 15. A data bit is therefore inverted when the two stages agree and left alone when they disagree. Each half advances only on its own one-cycle timing strobe. Each half also has a bypass input that forces the tap term to zero for that bit, so data crosses unchanged. A synchronous reset loads both registers with a single set bit in stage 1, which keeps them out of the all-zeros and all-ones states.

Top module: `scrdescr_top`

## Requirements
- R1: While `rst` is high, each clock edge loads both registers with stage 1 = 1 and every other stage = 0, sets `tx_dout` to 1 and sets `rx_dout` to 0.
- R2: A half whose strobe (`tx_en` or `rx_en`) is low keeps its register and its output unchanged, whatever its data and bypass inputs do.
- R3: On a `tx_en` edge with `tx_inh` low, `tx_dout` becomes `tx_din` XOR NOT(stage7 XOR stage15), using the register as it was before the edge. The same bit enters stage 1 while every stage k moves to stage k+1.
- R4: On an `rx_en` edge with `rx_inh` low, `rx_dout` becomes `rx_din` XOR NOT(stage7 XOR stage15), using the receive register as it was before the edge. `rx_din` itself enters stage 1.
- R5: On a `tx_en` edge with `tx_inh` high, `tx_dout` equals `tx_din`, and that bit is still shifted into stage 1.
- R6: On an `rx_en` edge with `rx_inh` high, `rx_dout` equals `rx_din`, and `rx_din` is still shifted into stage 1.
- R7: If the receive half is fed the transmit output bit for bit with both bypasses low, then from the 16th shared bit onward `rx_dout` reproduces the corresponding `tx_din`, whatever state the receive register started in.
- R8: The bypass inputs are sampled only on their own strobe edge. Toggling a bypass input from one bit to the next affects only the bit sampled with it.
- R9: After reset, a constant-zero `tx_din` stream with `tx_inh` low yields a `tx_dout` stream that holds both ones and zeros within 30 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit bit strobe |
| tx_din | input | 1 | Transmit serial data in |
| tx_inh | input | 1 | Transmit bypass (tap term forced to 0) |
| tx_dout | output | 1 | Scrambled serial data, registered |
| rx_en | input | 1 | Receive bit strobe |
| rx_din | input | 1 | Received line bit |
| rx_inh | input | 1 | Receive bypass (tap term forced to 0) |
| rx_dout | output | 1 | Descrambled serial data, registered |

## Verification
The two halves run on independent strobes, so a transmit step and a receive step can land on the same clock edge. The self-synchronization run provokes this on purpose. Both strobes pulse together while the receive input carries the line bit the transmitter is producing on that very edge, and the receive register first carries a scrambled history from earlier receive-only bits. The scoreboard judges each edge against a reference model of both registers, and from the 16th shared bit onward it also compares `rx_dout` directly with the original transmit data. A second kind of coincidence is a bypass toggle on the same edge as a data bit. Those bits are checked one by one against the model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_LEN   = 15;
  localparam int unsigned SCR_TAP_A = 7;
  localparam int unsigned SCR_TAP_B = 15;

  // Preset: only stage 1 set, all others clear.
  function automatic logic [SCR_LEN-1:0] preset_word();
    logic [SCR_LEN-1:0] w;
    w    = '0;
    w[0] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/scr_tap.sv
module scr_tap #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B
) (
  input  logic [LEN-1:0] stages,
  input  logic           bypass,
  output logic           flip
);
  localparam int unsigned IA = TAP_A - 1;
  localparam int unsigned IB = TAP_B - 1;

  // Invert when the two tapped stages agree; bypass forces no inversion.
  always_comb begin
    flip = ~(stages[IA] ^ stages[IB]) & ~bypass;
  end
endmodule

// File: rtl/scr_tx.sv
module scr_tx #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  input  logic inh,
  output logic dout
);
  logic [LEN-1:0] shreg;
  logic           flip;
  logic           line_bit;

  scr_tap #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_tap (
    .stages(shreg),
    .bypass(inh),
    .flip  (flip)
  );

  assign line_bit = din ^ flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= scr_pkg::preset_word();
    end else if (en) begin
      shreg <= {shreg[LEN-2:0], line_bit};
    end
  end

  // Output is stage 1 itself: no extra latency.
  assign dout = shreg[0];
endmodule

// File: rtl/scr_rx.sv
module scr_rx #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  input  logic inh,
  output logic dout
);
  logic [LEN-1:0] shreg;
  logic           flip;
  logic           out_q;

  scr_tap #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_tap (
    .stages(shreg),
    .bypass(inh),
    .flip  (flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= scr_pkg::preset_word();
      out_q <= 1'b0;
    end else if (en) begin
      shreg <= {shreg[LEN-2:0], din};
      out_q <= din ^ flip;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/scrdescr_top.sv
module scrdescr_top #(
  parameter int unsigned LEN   = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_A = scr_pkg::SCR_TAP_A,
  parameter int unsigned TAP_B = scr_pkg::SCR_TAP_B
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_din,
  input  logic tx_inh,
  output logic tx_dout,
  input  logic rx_en,
  input  logic rx_din,
  input  logic rx_inh,
  output logic rx_dout
);
  scr_tx #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_tx (
    .clk (clk),
    .rst (rst),
    .en  (tx_en),
    .din (tx_din),
    .inh (tx_inh),
    .dout(tx_dout)
  );

  scr_rx #(.LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_rx (
    .clk (clk),
    .rst (rst),
    .en  (rx_en),
    .din (rx_din),
    .inh (rx_inh),
    .dout(rx_dout)
  );
endmodule

// File: rtl/scrdescr_chk.sv
module scrdescr_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic tx_din,
  input logic tx_inh,
  input logic tx_dout,
  input logic rx_en,
  input logic rx_din,
  input logic rx_inh,
  input logic rx_dout
);
  // R1: on the first edge after reset release the outputs show the reset values
  p_reset_vals_r1: assert property (@(posedge clk)
    $fell(rst) |-> (tx_dout == 1'b1 && rx_dout == 1'b0));

  // R2: an idle strobe keeps the output
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> $stable(tx_dout));
  p_rx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> $stable(rx_dout));

  // R5: transmit bypass passes data unchanged
  p_tx_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_inh) |=> (tx_dout == $past(tx_din)));

  // R6: receive bypass passes data unchanged
  p_rx_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_en && rx_inh) |=> (rx_dout == $past(rx_din)));
endmodule

bind scrdescr_top scrdescr_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .tx_en  (tx_en),
  .tx_din (tx_din),
  .tx_inh (tx_inh),
  .tx_dout(tx_dout),
  .rx_en  (rx_en),
  .rx_din (rx_din),
  .rx_inh (rx_inh),
  .rx_dout(rx_dout)
);

// File: tb/test_scrdescr_top.sv
`timescale 1ns/1ps
module test_scrdescr_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, tx_din = 1'b0, tx_inh = 1'b0;
  logic rx_en = 1'b0, rx_din = 1'b0, rx_inh = 1'b0;
  logic tx_dout, rx_dout;

  always #10 clk = ~clk; // 50 MHz

  scrdescr_top i_scrdescr_top (
    .clk(clk), .rst(rst),
    .tx_en(tx_en), .tx_din(tx_din), .tx_inh(tx_inh), .tx_dout(tx_dout),
    .rx_en(rx_en), .rx_din(rx_din), .rx_inh(rx_inh), .rx_dout(rx_dout)
  );

  typedef struct {
    bit    ck_tx;
    bit    ex_tx;
    bit    ck_rx;
    bit    ex_rx;
    string req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;

  // Reference model: index k is stage k.
  logic [15:1] mtx, mrx;
  logic        cur_tx, cur_rx;

  function automatic logic tapf(logic [15:1] m, logic inh);
    return inh ? 1'b0 : ~(m[7] ^ m[15]);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mtx = 15'd1; mrx = 15'd1; cur_tx = 1'b1; cur_rx = 1'b0;
  endtask

  // Driver: drives one edge, predicts, pushes expectation.
  task automatic step(input logic te, input logic td, input logic ti,
                      input logic re, input logic rd, input logic ri,
                      input string req, input bit use_rx_exp, input logic rx_exp,
                      output logic line);
    item_t it;
    @(negedge clk);
    tx_en = te; tx_din = td; tx_inh = ti;
    rx_en = re; rx_din = rd; rx_inh = ri;
    if (te) begin
      cur_tx = td ^ tapf(mtx, ti);
      mtx = {mtx[14:1], cur_tx};
    end
    if (re) begin
      cur_rx = rd ^ tapf(mrx, ri);
      mrx = {mrx[14:1], rd};
    end
    line = cur_tx;
    it.ck_tx = 1'b1; it.ex_tx = cur_tx;
    it.ck_rx = 1'b1; it.ex_rx = use_rx_exp ? rx_exp : cur_rx;
    it.req = req;
    @(posedge clk);
    #1;
    q.push_back(it);
  endtask

  // Monitor: compares one expectation per negedge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.ck_tx) check({it.req, " tx_dout"}, tx_dout, it.ex_tx);
      if (it.ck_rx) check({it.req, " rx_dout"}, rx_dout, it.ex_rx);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_en = 0; rx_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired (all) actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ln;
    logic [14:0] lfsr;
    int ones;
    lfsr = 15'h2b5d;
    do_reset();
    // R1: reset values at ports
    check("R1 tx reset", tx_dout, 1'b1);
    check("R1 rx reset", rx_dout, 1'b0);

    // R3/R4: random data on both halves independently (R1 preset seen via model)
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      step(1'b1, lfsr[0], 1'b0, 1'b1, lfsr[3], 1'b0, "R3_R4", 0, 1'b0, ln);
    end
    // R2: strobes low, inputs wiggle
    for (int i = 0; i < 6; i++)
      step(1'b0, i[0], i[1], 1'b0, ~i[0], i[2], "R2", 0, 1'b0, ln);
    for (int i = 0; i < 10; i++)  // proves registers untouched
      step(1'b1, i[1], 1'b0, 1'b1, i[0], 1'b0, "R2 after-idle", 0, 1'b0, ln);
    // R5/R6: bypass held
    for (int i = 0; i < 12; i++)
      step(1'b1, i[0] ^ i[2], 1'b1, 1'b1, i[1], 1'b1, "R5_R6", 0, 1'b0, ln);
    // R8: bypass toggling per bit
    for (int i = 0; i < 20; i++)
      step(1'b1, i[1] ^ i[3], i[0], 1'b1, i[2], ~i[0], "R8", 0, 1'b0, ln);

    // R9: lockup avoidance from reset
    do_reset();
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9", 0, 1'b0, ln);
      if (ln) ones++;
    end
    total++;
    if (ones == 0 || ones == 30) begin
      bad++;
      $display("FAIL R9 ones actual=%0d expected=between 1 and 29", ones);
    end

    // R7: desync the receiver, then loop back
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      step(1'b0, 1'b0, 1'b0, 1'b1, lfsr[5], 1'b0, "R7 prep", 0, 1'b0, ln);
    end
    for (int i = 0; i < 60; i++) begin
      logic d, s;
      lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
      d = lfsr[0];
      s = d ^ tapf(mtx, 1'b0);   // line bit the transmitter will emit now
      step(1'b1, d, 1'b0, 1'b1, s, 1'b0, "R7", (i >= 15), d, ln);
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule